// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block computes one integer multiply or one integer divide at a time, over several clock cycles. A request carries an opcode (multiply or divide), a signedness flag, a width flag (32-bit or 64-bit operands) and two operands. The block accepts it only when it is idle. It works on operand magnitudes and corrects the signs in its last step. When the result is ready it presents it on two 64-bit result registers, with a one-cycle valid pulse.

A multiply produces the exact 128-bit product of the two extended operands. It consumes the multiplier 16 bits per cycle, so its latency depends only on the operand width. A divide first counts the leading zeros of both magnitudes. It aligns the divisor under the dividend's top bit and then runs one restoring step for each significant quotient bit. A small quotient therefore finishes early, and a divisor larger than the dividend finishes at once. The busy output tells the surrounding logic when a new request would be dropped.

Top module: `mdu_iter`

## Requirements
- R1: A 32-bit multiply (`req_wide`=0) raises `res_valid` exactly 4 cycles after the accepting clock edge. `{res_hi,res_lo}` holds the 128-bit product of the operands, each extended to 128 bits: sign extension when `req_signed`=1, zero extension otherwise.
- R2: A 64-bit multiply (`req_wide`=1) raises `res_valid` exactly 6 cycles after acceptance. The 128-bit product is formed the same way as in R1.
- R3: A divide raises `res_valid` exactly 2+Q cycles after acceptance. Q = lz(|b|) - lz(|a|) + 1 when |b| is nonzero and |a| >= |b|, and Q = 0 otherwise. Here lz counts leading zeros of a 64-bit magnitude.
- R4: For a divide with a nonzero divisor, `res_lo` is the quotient truncated toward zero and `res_hi` is the remainder. The remainder carries the dividend's sign. Unsigned divides use plain magnitudes.
- R5: A divide by zero completes 2 cycles after acceptance. It returns all ones in `res_lo` and the extended dividend in `res_hi`.
- R6: `busy` is 1 from the cycle after acceptance until the result cycle. In the result cycle `res_valid` is 1 for exactly one cycle and `busy` is 0.
- R7: A request presented while `busy` is 1 is dropped. The running operation's result and latency are unchanged, and no second result follows.
- R8: A request presented in the cycle `res_valid` is 1 is accepted at the next edge. `busy` is 1 in the following cycle.
- R9: During and after reset, `busy` and `res_valid` are 0 and both result registers are 0.
- R10: With `req_wide`=0, operand bits 63:32 are ignored. Bits 31:0 are extended to 64 bits according to `req_signed` before the operation.
- R11: `res_hi` and `res_lo` keep their value in every cycle except the result cycle of the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_div | input | 1 | 1 = divide, 0 = multiply |
| req_signed | input | 1 | 1 = two's-complement operands |
| req_wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| req_a | input | 64 | Multiplicand or dividend |
| req_b | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in progress; requests dropped |
| res_valid | output | 1 | One-cycle result strobe |
| res_hi | output | 64 | Product high half or remainder |
| res_lo | output | 64 | Product low half or quotient |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. The bench provokes this by holding a second request on the inputs for the whole time the first one runs. It then checks three things: the first result appears unaltered, `busy` rises in the very next cycle, and the second result arrives after that operation's own latency, counted from the edge after the result cycle. A request pulsed mid-operation is judged separately. The running result must be intact and no extra result may appear.

// File: rtl/mdu_iter.sv
module mdu_iter #(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  parameter int CHUNK = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_div,
  input  logic            req_signed,
  input  logic            req_wide,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  output logic            busy,
  output logic            res_valid,
  output logic [XLEN-1:0] res_hi,
  output logic [XLEN-1:0] res_lo
);
  localparam int MW     = 2 * XLEN;
  localparam int CW     = $clog2(XLEN + 1);
  localparam int STEP_W = XLEN / CHUNK;
  localparam int STEP_H = HALF / CHUNK;

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_ITER, S_FIX} st_t;

  st_t             st;
  logic            op_div, op_wide, neg_q, neg_r;
  logic [XLEN-1:0] ma, mb, quo, rem, dsh;
  logic [MW-1:0]   acc, mcand;
  logic [CW-1:0]   cnt;

  function automatic logic [CW-1:0] lzc(input logic [XLEN-1:0] v);
    lzc = CW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (v[i]) lzc = CW'(XLEN - 1 - i);
  endfunction

  logic [XLEN-1:0] ea, eb;
  logic            sa, sb, accept;
  assign ea = req_wide ? req_a : {{(XLEN-HALF){req_signed & req_a[HALF-1]}}, req_a[HALF-1:0]};
  assign eb = req_wide ? req_b : {{(XLEN-HALF){req_signed & req_b[HALF-1]}}, req_b[HALF-1:0]};
  assign sa = req_signed & ea[XLEN-1];
  assign sb = req_signed & eb[XLEN-1];
  assign accept = req_valid && st == S_IDLE;
  assign busy = st != S_IDLE;

  logic [CW-1:0] lza, lzb, qbits;
  assign lza   = lzc(ma);
  assign lzb   = lzc(mb);
  assign qbits = (mb != '0 && ma >= mb) ? CW'(lzb - lza + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      op_div    <= 1'b0;
      op_wide   <= 1'b0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      ma        <= '0;
      mb        <= '0;
      quo       <= '0;
      rem       <= '0;
      dsh       <= '0;
      acc       <= '0;
      mcand     <= '0;
      cnt       <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_div  <= req_div;
          op_wide <= req_wide;
          neg_q   <= sa ^ sb;
          neg_r   <= sa;
          ma      <= sa ? -ea : ea;
          mb      <= sb ? -eb : eb;
          st      <= S_NORM;
        end
        S_NORM: begin
          if (op_div) begin
            rem <= ma;
            quo <= '0;
            dsh <= mb << (lzb - lza);
            cnt <= qbits;
            st  <= (qbits == '0) ? S_FIX : S_ITER;
          end else begin
            acc   <= '0;
            mcand <= MW'(ma);
            cnt   <= op_wide ? CW'(STEP_W) : CW'(STEP_H);
            st    <= S_ITER;
          end
        end
        S_ITER: begin
          if (op_div) begin
            if (rem >= dsh) begin
              rem <= rem - dsh;
              quo <= {quo[XLEN-2:0], 1'b1};
            end else begin
              quo <= {quo[XLEN-2:0], 1'b0};
            end
            dsh <= dsh >> 1;
          end else begin
            acc   <= acc + mcand * MW'(mb[CHUNK-1:0]);
            mcand <= mcand << CHUNK;
            mb    <= mb >> CHUNK;
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIX;
        end
        default: begin
          res_valid <= 1'b1;
          st        <= S_IDLE;
          if (op_div) begin
            res_lo <= (mb == '0) ? '1 : (neg_q ? -quo : quo);
            res_hi <= neg_r ? -rem : rem;
          end else begin
            {res_hi, res_lo} <= neg_q ? -acc : acc;
          end
        end
      endcase
    end
  end
endmodule

module mdu_iter_chk #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_div,
  input logic            req_wide,
  input logic [XLEN-1:0] req_b,
  input logic            busy,
  input logic            res_valid,
  input logic [XLEN-1:0] res_hi,
  input logic [XLEN-1:0] res_lo
);
  logic       div_l, wide_l, bz_l;
  logic [7:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_l <= 1'b0; wide_l <= 1'b0; bz_l <= 1'b0; lat <= '0;
    end else if (req_valid && !busy) begin
      div_l  <= req_div;
      wide_l <= req_wide;
      bz_l   <= req_wide ? (req_b == '0) : (req_b[HALF-1:0] == '0);
      lat    <= '0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  assert_mul32_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !div_l && !wide_l |-> lat == 8'd4);
  assert_mul64_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !div_l && wide_l |-> lat == 8'd6);
  assert_div_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && div_l |-> lat >= 8'd2 && lat <= 8'(XLEN + 2));
  assert_divzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && div_l && bz_l |-> res_lo == '1 && lat == 8'd2);
  assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_hi) && $stable(res_lo));
endmodule

bind mdu_iter mdu_iter_chk #(.XLEN(XLEN), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
  .req_wide(req_wide), .req_b(req_b), .busy(busy), .res_valid(res_valid),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/mdu_iter_tb.sv
module mdu_iter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_div = 1'b0, req_signed = 1'b0, req_wide = 1'b0;
  logic [63:0] req_a = '0, req_b = '0;
  logic        busy, res_valid;
  logic [63:0] res_hi, res_lo;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mdu_iter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
    .req_signed(req_signed), .req_wide(req_wide), .req_a(req_a), .req_b(req_b),
    .busy(busy), .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lz64(input logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return 63 - i;
    return 64;
  endfunction

  function automatic logic [63:0] ext(input logic [63:0] v, input logic sg, input logic wd);
    if (wd) return v;
    return sg ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
  endfunction

  // expected results and latency from the requirements
  task automatic expect_op(input logic dv, sg, wd, input logic [63:0] a, b,
                           output logic [127:0] exp, output int lat);
    logic [63:0] ea, eb, ma, mb, q, r;
    logic        sa, sb;
    logic [127:0] xa, xb;
    ea = ext(a, sg, wd); eb = ext(b, sg, wd);
    sa = sg & ea[63]; sb = sg & eb[63];
    ma = sa ? -ea : ea; mb = sb ? -eb : eb;
    if (!dv) begin
      xa = sg ? {{64{ea[63]}}, ea} : {64'b0, ea};
      xb = sg ? {{64{eb[63]}}, eb} : {64'b0, eb};
      exp = xa * xb;
      lat = wd ? 6 : 4;
    end else if (mb == 0) begin
      exp = {ea, 64'hFFFF_FFFF_FFFF_FFFF};
      lat = 2;
    end else begin
      q = ma / mb; r = ma % mb;
      if (sa ^ sb) q = -q;
      if (sa) r = -r;
      exp = {r, q};
      lat = 2 + ((ma >= mb) ? (lz64(mb) - lz64(ma) + 1) : 0);
    end
  endtask

  function automatic string tag_of(input logic dv, wd, input logic [63:0] b);
    string t;
    if (!dv) t = wd ? "R2" : "R1";
    else if (ext(b, 1'b0, wd) == 0) t = "R5";
    else t = "R4/R3";
    if (!wd) t = {t, " R10"};
    return t;
  endfunction

  task automatic drive(input logic dv, sg, wd, input logic [63:0] a, b);
    req_div = dv; req_signed = sg; req_wide = wd; req_a = a; req_b = b;
  endtask

  task automatic do_op(input logic dv, sg, wd, input logic [63:0] a, b);
    logic [127:0] exp;
    int lat, cyc;
    string t;
    expect_op(dv, sg, wd, a, b, exp, lat);
    t = tag_of(dv, wd, b);
    @(negedge clk);
    drive(dv, sg, wd, a, b); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !res_valid, "R6 busy after accept", {126'b0, busy, res_valid}, 128'h2);
    cyc = 0;
    while (!res_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk(!busy, "R6 busy low at result", {127'b0, busy}, 128'h0);
    chk({res_hi, res_lo} == exp, {t, " value"}, {res_hi, res_lo}, exp);
    chk(cyc == lat, {t, " latency"}, 128'(cyc), 128'(lat));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam int NV = 10;
  logic [31:0] v32 [NV] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7, 32'hFFFF_FFFF,
                            32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_1234, 32'hDEAD_BEEF};
  logic [63:0] v64 [NV] = '{64'h0, 64'h1, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF,
                            64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                            64'h1_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h10,
                            64'h1_2345_6789};

  initial begin
    logic [127:0] e1, e2, held;
    int l1, l2, cyc;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid && res_hi == 0 && res_lo == 0, "R9 reset during",
        {res_hi[62:0], res_lo, busy}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid && res_hi == 0 && res_lo == 0, "R9 reset after",
        {res_hi[62:0], res_lo, busy}, 128'h0);

    // sweeps: 32-bit with garbage upper bits (R10), then 64-bit
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          do_op(m[1], m[0], 1'b0, {32'hA5A5_5A5A, v32[i]}, {32'h3C3C_C3C3, v32[j]});
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          do_op(m[1], m[0], 1'b1, v64[i], v64[j]);

    // R7: request pulsed while busy is dropped
    expect_op(1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h7, e1, l1);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h7); req_valid = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 64'h5, 64'h9);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!res_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk({res_hi, res_lo} == e1, "R7 running result kept", {res_hi, res_lo}, e1);
    chk(cyc == l1, "R7 latency unchanged", 128'(cyc), 128'(l1));
    held = {res_hi, res_lo};
    repeat (4) begin
      @(negedge clk);
      chk(!res_valid && !busy, "R7 no extra result", {126'b0, busy, res_valid}, 128'h0);
    end
    chk({res_hi, res_lo} == held, "R11 result held", {res_hi, res_lo}, held);

    // R8: completion and acceptance in the same cycle
    expect_op(1'b1, 1'b0, 1'b0, 64'h0000_0000_0001_0000, 64'h3, e1, l1);
    expect_op(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'h1234_5678_9ABC, e2, l2);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 64'h0000_0000_0001_0000, 64'h3); req_valid = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'h1234_5678_9ABC);
    cyc = 0;
    while (!res_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk({res_hi, res_lo} == e1, "R8 first result", {res_hi, res_lo}, e1);
    chk(cyc == l1, "R3 first latency", 128'(cyc), 128'(l1));
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !res_valid, "R8 accepted in result cycle", {126'b0, busy, res_valid}, 128'h2);
    cyc = 1;
    while (!res_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk({res_hi, res_lo} == e2, "R8 second result", {res_hi, res_lo}, e2);
    chk(cyc == l2 + 1, "R8 second latency", 128'(cyc), 128'(l2 + 1));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule